// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the settings of a frequency synthesizer: a 9-bit feedback divide value, a 2-bit output divide code, and a 2-bit test selector. Two ways load them. A set of parallel pins is qualified by an active-low strobe. A three-line serial port carries data, a shift clock and a latch line. The block turns the output divide code into a one-hot divide ratio. It drives a test pin through a four-way selector. A master reset input gates the synthesizer output enable.

Every control pin is asynchronous to the block. Each one passes through a synchronizer on the system clock, and edges of the serial shift clock and of the latch line are found from the synchronized samples. The whole block therefore runs on one clock. The feedback divider output and the synthesized clock come in as plain digital inputs, so they can be routed to the test pin. A status flag reports a feedback divide value outside the lock window of 8 to 28. The flag does not stop a value from being loaded.

Top module: `synth_cfg_port`

## Requirements
- R1: While `cfg_pload_n` is low (parallel mode), `m_val`/`n_code` follow `cfg_m_pin`/`cfg_n_pin`, and serial clock and latch activity has no effect on them.
- R2: After `cfg_pload_n` rises, `m_val` and `n_code` keep their last parallel values whatever the pins do, until the strobe goes low again or a serial transfer occurs.
- R3: While in parallel mode, `test_out` is low regardless of `t_sel` and of the test sources.
- R4: With `cfg_pload_n` high, each rising `ser_clk` shifts `ser_din` into a 14-bit frame register, first bit first: test bits (high then low), one don't-care pad bit, output code (high then low), then feedback value bit 8 down to bit 0. Shifting with `ser_latch` low does not change the active settings.
- R5: A rising `ser_latch` (with `cfg_pload_n` high) copies the frame into `m_val`, `n_code` and `t_sel`. These values then stay put after `ser_latch` falls.
- R6: While `ser_latch` is high and `cfg_pload_n` is high, every rising `ser_clk` shifts the frame and updates `m_val`/`n_code`/`t_sel` at once from the shifted frame.
- R7: Outside parallel mode and master reset, `test_out` is selected by `t_sel`: 00 gives low, 01 gives `ser_din`, 10 gives `fb_div_in`, and 11 gives `fout_in`.
- R8: `div_ratio` is one-hot: code 00 gives 1, 01 gives 2, 10 gives 4, and 11 gives 8.
- R9: While `master_rst` is high, `fout_en` and `test_out` are low, and `m_val`/`n_code`/`t_sel` are unchanged. When it drops, `fout_en` returns high.
- R10: One cycle after `m_val` changes, `m_range_err` is high exactly when `m_val` < 8 or `m_val` > 28.
- R11: An input change driven before rising clock edge k shows on the outputs after edge k+2 and not before. Synchronous `rst` clears all settings to zero, `div_ratio` to 1, and the flags and `test_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pload_n | input | 1 | Parallel load strobe, low = transparent |
| cfg_m_pin | input | 9 | Parallel feedback divide value |
| cfg_n_pin | input | 2 | Parallel output divide code |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data |
| ser_latch | input | 1 | Serial latch line |
| fb_div_in | input | 1 | Feedback divider output, a test source |
| fout_in | input | 1 | Synthesized clock, a test source |
| master_rst | input | 1 | Master reset, gates the output enable |
| m_val | output | 9 | Active feedback divide value |
| n_code | output | 2 | Active output divide code |
| t_sel | output | 2 | Active test selector |
| div_ratio | output | 4 | One-hot output divide ratio |
| test_out | output | 1 | Test pin |
| fout_en | output | 1 | Synthesizer output enable |
| m_range_err | output | 1 | Feedback value outside the lock window |

## Verification
Some rules are checked on every cycle by the assertions. Parallel pass-through, holding of the settings when no load is under way, transfer from the frame on a latch, forcing of the test pin low, the ratio encoding, the range flag and the master-reset gate are all covered this way. Other behaviour only the bench scenarios can show. That includes the exact frame order and the pad slot, the values seen partway through a flow-through shift, the three-edge synchronizer latency, and settings surviving master reset and later pin changes. The bench's reference model follows the same input history and is compared on every clock.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int PAD_W   = 1;
  localparam int FRAME_W = T_W + PAD_W + N_W + M_W;
  localparam int R_W     = 1 << N_W;

  typedef enum logic [T_W-1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDATA = 2'b01,
    TSEL_FBDIV = 2'b10,
    TSEL_FOUT  = 2'b11
  } tsel_e;

  typedef struct packed {
    logic [T_W-1:0]   t;
    logic [PAD_W-1:0] pad;
    logic [N_W-1:0]   n;
    logic [M_W-1:0]   m;
  } frame_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import synth_cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           sin,
  output logic [M_W-1:0] nxt_m,
  output logic [N_W-1:0] nxt_n,
  output logic [T_W-1:0] nxt_t
);
  frame_t q, q_nxt;

  always_comb begin
    if (shift_en) q_nxt = frame_t'({q[FRAME_W-2:0], sin});
    else          q_nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

  assign nxt_m = q_nxt.m;
  assign nxt_n = q_nxt.n;
  assign nxt_t = q_nxt.t;

  // R4: newest bit lands in the low end, the rest stay still when idle
  p_shift_in_r4: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (q[0] == $past(sin)));
  p_shift_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter int M_MIN = 8,
  parameter int M_MAX = 28
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_mode,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_xfer,
  input  logic [M_W-1:0] ser_m,
  input  logic [N_W-1:0] ser_n,
  input  logic [T_W-1:0] ser_t,
  output logic [M_W-1:0] m_q,
  output logic [N_W-1:0] n_q,
  output logic [T_W-1:0] t_q,
  output logic [R_W-1:0] ratio_q,
  output logic           m_bad_q
);
  localparam logic [M_W-1:0] M_LO = M_W'(M_MIN);
  localparam logic [M_W-1:0] M_HI = M_W'(M_MAX);

  logic [M_W-1:0] m_nxt;
  logic [N_W-1:0] n_nxt;
  logic [T_W-1:0] t_nxt;

  always_comb begin
    m_nxt = m_q;
    n_nxt = n_q;
    t_nxt = t_q;
    if (par_mode) begin
      m_nxt = par_m;
      n_nxt = par_n;
    end else if (ser_xfer) begin
      m_nxt = ser_m;
      n_nxt = ser_n;
      t_nxt = ser_t;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q     <= '0;
      n_q     <= '0;
      t_q     <= '0;
      ratio_q <= R_W'(1);
      m_bad_q <= 1'b0;
    end else begin
      m_q     <= m_nxt;
      n_q     <= n_nxt;
      t_q     <= t_nxt;
      ratio_q <= R_W'(1) << n_nxt;
      m_bad_q <= (m_q < M_LO) || (m_q > M_HI);
    end
  end

  p_par_pass_r1: assert property (@(posedge clk) disable iff (rst)
    par_mode |=> (m_q == $past(par_m)) && (n_q == $past(par_n)));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!par_mode && !ser_xfer) |=> ($stable(m_q) && $stable(n_q) && $stable(t_q)));
  p_ser_load_r5: assert property (@(posedge clk) disable iff (rst)
    (!par_mode && ser_xfer) |=> (m_q == $past(ser_m)) && (t_q == $past(ser_t)));
  p_ratio_r8: assert property (@(posedge clk) disable iff (rst)
    ratio_q == (R_W'(1) << n_q));
  p_range_hi_r10: assert property (@(posedge clk) disable iff (rst)
    (m_q > M_HI) |=> m_bad_q);
  p_range_ok_r10: assert property (@(posedge clk) disable iff (rst)
    ((m_q >= M_LO) && (m_q <= M_HI)) |=> !m_bad_q);
endmodule

// File: rtl/cfg_testmux.sv
module cfg_testmux
  import synth_cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           force_low,
  input  logic [T_W-1:0] tsel,
  input  logic           sdata,
  input  logic           fb,
  input  logic           fout,
  output logic           test_q
);
  logic pick;

  always_comb begin
    unique case (tsel_e'(tsel))
      TSEL_LOW:   pick = 1'b0;
      TSEL_SDATA: pick = sdata;
      TSEL_FBDIV: pick = fb;
      TSEL_FOUT:  pick = fout;
      default:    pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) test_q <= 1'b0;
    else     test_q <= pick & ~force_low;
  end

  p_force_low_r3: assert property (@(posedge clk) disable iff (rst)
    force_low |=> !test_q);
  p_sel_sdata_r7: assert property (@(posedge clk) disable iff (rst)
    (!force_low && tsel == TSEL_SDATA) |=> (test_q == $past(sdata)));
  p_sel_low_r7: assert property (@(posedge clk) disable iff (rst)
    (tsel == TSEL_LOW) |=> !test_q);
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_MIN       = 8,
  parameter int M_MAX       = 28
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_pload_n,
  input  logic [M_W-1:0] cfg_m_pin,
  input  logic [N_W-1:0] cfg_n_pin,
  input  logic           ser_clk,
  input  logic           ser_din,
  input  logic           ser_latch,
  input  logic           fb_div_in,
  input  logic           fout_in,
  input  logic           master_rst,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic [T_W-1:0] t_sel,
  output logic [R_W-1:0] div_ratio,
  output logic           test_out,
  output logic           fout_en,
  output logic           m_range_err
);
  localparam int CW = 7;
  localparam int I_PL = 6, I_SCK = 5, I_SD = 4, I_SL = 3, I_MR = 2, I_FB = 1, I_FO = 0;
  localparam int PW = M_W + N_W;

  logic [CW-1:0] ctl_s;
  logic [PW-1:0] pin_s;
  logic          sck_p, sl_p;

  cfg_sync #(.W(CW), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .d({cfg_pload_n, ser_clk, ser_din, ser_latch, master_rst, fb_div_in, fout_in}),
    .q(ctl_s));

  cfg_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst(rst), .d({cfg_m_pin, cfg_n_pin}), .q(pin_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p   <= 1'b0;
      sl_p    <= 1'b0;
      fout_en <= 1'b0;
    end else begin
      sck_p   <= ctl_s[I_SCK];
      sl_p    <= ctl_s[I_SL];
      fout_en <= ~ctl_s[I_MR];
    end
  end

  logic par_mode, sck_rise, sl_rise, shift_en, ser_xfer;
  assign par_mode = ~ctl_s[I_PL];
  assign sck_rise = ctl_s[I_SCK] & ~sck_p;
  assign sl_rise  = ctl_s[I_SL] & ~sl_p;
  assign shift_en = ~par_mode & sck_rise;
  assign ser_xfer = ~par_mode & (sl_rise | (ctl_s[I_SL] & sck_rise));

  logic [M_W-1:0] fr_m;
  logic [N_W-1:0] fr_n;
  logic [T_W-1:0] fr_t;

  cfg_shift u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .sin(ctl_s[I_SD]),
    .nxt_m(fr_m), .nxt_n(fr_n), .nxt_t(fr_t));

  cfg_regs #(.M_MIN(M_MIN), .M_MAX(M_MAX)) u_regs (
    .clk(clk), .rst(rst), .par_mode(par_mode),
    .par_m(pin_s[PW-1:N_W]), .par_n(pin_s[N_W-1:0]),
    .ser_xfer(ser_xfer), .ser_m(fr_m), .ser_n(fr_n), .ser_t(fr_t),
    .m_q(m_val), .n_q(n_code), .t_q(t_sel), .ratio_q(div_ratio), .m_bad_q(m_range_err));

  cfg_testmux u_tmux (
    .clk(clk), .rst(rst), .force_low(par_mode | ctl_s[I_MR]), .tsel(t_sel),
    .sdata(ctl_s[I_SD]), .fb(ctl_s[I_FB]), .fout(ctl_s[I_FO]), .test_q(test_out));

  p_outen_off_r9: assert property (@(posedge clk) disable iff (rst)
    ctl_s[I_MR] |=> (!fout_en && !test_out));
  p_outen_on_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl_s[I_MR] |=> fout_en);
  p_mres_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_s[I_MR] && !par_mode && !ser_xfer) |=> $stable(m_val));
endmodule

// File: tb/tb_synth_cfg_port.sv
`timescale 1ns/1ps
module tb_synth_cfg_port;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pl_n = 1'b0, sck = 1'b0, sd = 1'b0, sl = 1'b0, mr = 1'b0, fb = 1'b0, fo = 1'b0;
  logic [8:0] mp = '0;
  logic [1:0] np = '0;
  logic [8:0] m_val;
  logic [1:0] n_code, t_sel;
  logic [3:0] div_ratio;
  logic test_out, fout_en, m_range_err;

  always #2.5 clk = ~clk;

  synth_cfg_port dut (
    .clk(clk), .rst(rst), .cfg_pload_n(pl_n), .cfg_m_pin(mp), .cfg_n_pin(np),
    .ser_clk(sck), .ser_din(sd), .ser_latch(sl), .fb_div_in(fb), .fout_in(fo),
    .master_rst(mr), .m_val(m_val), .n_code(n_code), .t_sel(t_sel),
    .div_ratio(div_ratio), .test_out(test_out), .fout_en(fout_en),
    .m_range_err(m_range_err));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: input history, serial frame and settings
  logic [17:0] hist [3] = '{default: '0};
  logic [17:0] cur, prv;
  logic [13:0] e_fr = '0;
  logic [8:0]  e_m = '0;
  logic [1:0]  e_n = '0, e_t = '0;
  logic        e_test = 1'b0, e_en = 1'b0, e_bad = 1'b0;
  logic        srise, xfer;

  always @(posedge clk) begin
    cur = hist[1];
    prv = hist[2];
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = rst ? 18'd0 : {pl_n, sck, sd, sl, mr, fb, fo, mp, np};
    if (rst) begin
      e_fr = '0; e_m = '0; e_n = '0; e_t = '0;
      e_test = 1'b0; e_en = 1'b0; e_bad = 1'b0;
    end else begin
      if (!cur[17] || cur[13]) e_test = 1'b0;
      else case (e_t)
        2'd0: e_test = 1'b0;
        2'd1: e_test = cur[15];
        2'd2: e_test = cur[12];
        default: e_test = cur[11];
      endcase
      e_en  = !cur[13];
      e_bad = (e_m < 9'd8) || (e_m > 9'd28);
      if (!cur[17]) begin
        e_m = cur[10:2];
        e_n = cur[1:0];
      end else begin
        srise = cur[16] && !prv[16];
        if (srise) e_fr = {e_fr[12:0], cur[15]};
        xfer = (cur[14] && !prv[14]) || (cur[14] && srise);
        if (xfer) begin
          e_m = e_fr[8:0];
          e_n = e_fr[10:9];
          e_t = e_fr[13:12];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 R2 R5 R6 m_val model", int'(m_val), int'(e_m));
      chk("R1 R4 n_code model", int'(n_code), int'(e_n));
      chk("R5 R6 t_sel model", int'(t_sel), int'(e_t));
      chk("R8 div_ratio model", int'(div_ratio), 1 << e_n);
      chk("R3 R7 test_out model", int'(test_out), int'(e_test));
      chk("R9 fout_en model", int'(fout_en), int'(e_en));
      chk("R10 m_range_err model", int'(m_range_err), int'(e_bad));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [13:0] fr, input int nbits);
    for (int i = 13; i > 13 - nbits; i--) begin
      sd = fr[i];
      sck = 1'b0; tick(3);
      sck = 1'b1; tick(3);
    end
    sck = 1'b0; tick(3);
  endtask

  task automatic load_frame(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
    send_bits({t, 1'b0, n, m}, 14);
    sl = 1'b1; tick(5);
    sl = 1'b0; tick(5);
  endtask

  initial begin
    tick(5);
    chk("R11 reset m_val", int'(m_val), 0);
    chk("R11 reset div_ratio", int'(div_ratio), 1);
    chk("R11 reset test/en", int'({test_out, fout_en, m_range_err}), 0);
    rst = 1'b0;

    mp = 9'd20; np = 2'd2; tick(6);
    chk("R1 m_val pass", int'(m_val), 20);
    chk("R8 ratio for code 2", int'(div_ratio), 4);
    chk("R3 test low in parallel", int'(test_out), 0);
    mp = 9'd21; tick(2);
    chk("R11 not yet after two edges", int'(m_val), 20);
    tick(1);
    chk("R11 updated after third edge", int'(m_val), 21);

    sl = 1'b1; sd = 1'b1; tick(4);
    sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    sl = 1'b0; sd = 1'b0; tick(4);
    chk("R1 serial ignored in parallel", int'(m_val), 21);

    pl_n = 1'b1; tick(4);
    mp = 9'd5; np = 2'd0; tick(6);
    chk("R2 m held after strobe rise", int'(m_val), 21);
    chk("R2 n held after strobe rise", int'(n_code), 2);

    send_bits({2'b01, 1'b1, 2'b01, 9'd25}, 14);
    chk("R4 shift alone leaves m", int'(m_val), 21);
    sl = 1'b1; tick(5);
    chk("R5 m after latch", int'(m_val), 25);
    chk("R4 frame order n", int'(n_code), 1);
    chk("R4 frame order t", int'(t_sel), 1);
    chk("R8 ratio for code 1", int'(div_ratio), 2);
    sl = 1'b0; tick(5);
    chk("R5 m kept after latch falls", int'(m_val), 25);
    chk("R10 25 in range", int'(m_range_err), 0);

    sd = 1'b1; tick(5);
    chk("R7 test follows data high", int'(test_out), 1);
    sd = 1'b0; tick(5);
    chk("R7 test follows data low", int'(test_out), 0);

    load_frame(2'b10, 2'b11, 9'd30);
    chk("R8 ratio for code 3", int'(div_ratio), 8);
    chk("R10 30 out of range", int'(m_range_err), 1);
    fb = 1'b1; tick(5);
    chk("R7 test follows fb", int'(test_out), 1);
    fb = 1'b0; tick(5);
    chk("R7 test follows fb low", int'(test_out), 0);

    load_frame(2'b11, 2'b00, 9'd8);
    chk("R10 8 at lower bound", int'(m_range_err), 0);
    fo = 1'b1; tick(5);
    chk("R7 test follows fout", int'(test_out), 1);
    mr = 1'b1; tick(5);
    chk("R9 enable low in master reset", int'(fout_en), 0);
    chk("R9 test low in master reset", int'(test_out), 0);
    chk("R9 m kept in master reset", int'(m_val), 8);
    mr = 1'b0; tick(5);
    chk("R9 enable back", int'(fout_en), 1);
    chk("R9 test back", int'(test_out), 1);

    load_frame(2'b00, 2'b10, 9'd28);
    fb = 1'b1; sd = 1'b1; tick(5);
    chk("R7 select 00 is low", int'(test_out), 0);
    chk("R10 28 at upper bound", int'(m_range_err), 0);
    fb = 1'b0; fo = 1'b0; sd = 1'b0;

    sl = 1'b1; tick(5);
    chk("R6 latch high keeps last frame", int'(m_val), 28);
    send_bits({2'b01, 1'b0, 2'b01, 9'd12}, 13);
    chk("R6 mid-frame flow value", int'(m_val), 262);
    send_bits({13'd0, 1'b0}, 1);
    chk("R6 m after flow frame", int'(m_val), 12);
    chk("R6 t after flow frame", int'(t_sel), 1);
    sl = 1'b0; tick(5);

    pl_n = 1'b0; mp = 9'd7; sd = 1'b1; tick(6);
    chk("R10 7 below range", int'(m_range_err), 1);
    chk("R3 test low again in parallel", int'(test_out), 0);
    mp = 9'd29; tick(6);
    chk("R10 29 above range", int'(m_range_err), 1);
    chk("R1 t kept in parallel", int'(t_sel), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule